// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-visible control port for a translation buffer. A processor reaches it through single-cycle register reads and writes, each carrying a register number, an extended-half flag and 32 bits of data. Through it, software picks a buffer slot, reads or writes that slot's tag word and its 64-bit translation word, sets the current process identifier and the zone protection word, and asks the lookup logic to find the slot that matches a virtual page.

The entry storage and the lookup logic sit outside. The block presents the selected slot number, reads that slot's tag, translation word and owner identifier back on combinational inputs, and writes the slot through one-cycle strobes. A search is a one-cycle combinational request: the block shows the page number, and the lookup unit answers with hit and slot in the same cycle. The current identifier and zone word are driven out for the lookup unit to use. The register numbers are: translation word 0, tag word 1, identifier 2, zone word 3, slot select 4, search 5.

Top module: `tlb_reg_ctrl`

## Requirements
- R1: After reset the slot select, identifier and zone registers all read as zero.
- R2: While `mmu_mode` is below 2 or `acc_lvl` is 0, every read returns zero, no entry strobe or search request is raised, and no register changes.
- R3: `ent_idx` carries bits 7:0 of the slot select register; a read of register 1 returns `ent_rd_tag`, a read of register 0 returns bits 31:0 of `ent_rd_lo`, and an extended read of register 0 returns bits 63:32.
- R4: A write to register 1 raises `ent_we_tag` for one cycle with `ent_wdata` equal to the written data and `ent_wtid` equal to bits 7:0 of the identifier; a write to register 0 raises `ent_we_lo`, or `ent_we_up` when the extended flag is set.
- R5: A permitted read of register 1 loads the identifier register with `ent_rd_tid`, zero-extended, at the end of the read cycle.
- R6: A write to register 4 replaces bits 30:0 of the slot select register; bit 31 keeps its value.
- R7: A permitted write to register 5 raises `srch_req` with `srch_vpn` equal to the data masked to bits 31:10; on `srch_hit` the slot select becomes `srch_idx` zero-extended (bit 31 cleared), on a miss bit 31 is set and bits 30:0 keep their value.
- R8: Register 5 reads as zero.
- R9: Reads of registers 0, 1, 2 and 3 return zero unless bit 0 of `acc_lvl` is set; register 4 is readable at any enabled level.
- R10: Writes to registers 2, 3 and 5 take effect only when `acc_lvl` is 2 or 3; writes to registers 0, 1 and 4 need only the enable of R2.
- R11: The extended flag is honoured only on register 0; an extended access to any other register reads zero and writes nothing.
- R12: Register numbers 6 and 7 read zero and writes to them change nothing.
- R13: A register written in one cycle returns its new value to a read in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_mode | input | 2 | Configured translation mode; below 2 disables the port |
| acc_lvl | input | 2 | Configured software access level |
| rd_en | input | 1 | Register read in this cycle |
| wr_en | input | 1 | Register write in this cycle |
| reg_num | input | 3 | Register number |
| ext | input | 1 | Selects the upper half of the translation word |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the read cycle |
| ent_idx | output | 8 | Selected buffer slot |
| ent_rd_tag | input | 32 | Tag word of the selected slot |
| ent_rd_lo | input | 64 | Translation word of the selected slot |
| ent_rd_tid | input | 8 | Owner identifier of the selected slot |
| ent_we_tag | output | 1 | Write tag word and owner identifier of the selected slot |
| ent_we_lo | output | 1 | Write lower half of the translation word |
| ent_we_up | output | 1 | Write upper half of the translation word |
| ent_wdata | output | 32 | Entry write data |
| ent_wtid | output | 8 | Owner identifier written with a tag |
| srch_req | output | 1 | Search request to the lookup unit |
| srch_vpn | output | 32 | Page number searched for |
| srch_hit | input | 1 | Lookup found a slot |
| srch_idx | input | 8 | Slot found by the lookup |
| pid_o | output | 8 | Current identifier for the lookup unit |
| zone_o | output | 32 | Zone protection word for the lookup unit |

## Verification
On every cycle the assertions check the enable gate, the refusal of extended access outside register 0, the level needed to search, that a tag write carries the current identifier, and the one-cycle landing of slot-select writes, search hits and identifier copies. Bit 31 of the slot select is not visible at any port except through a read, so the sticky miss flag, its survival across slot-select writes and its clearing by a later hit are shown only by the bench's read-back sequences, as are the read-level masking and the silence of unused register numbers.

// File: rtl/tlb_reg_ctrl.sv
module tlb_reg_ctrl #(
  parameter int DW       = 32,
  parameter int IDX_BITS = 8,
  parameter int TID_BITS = 8,
  parameter int RN_BITS  = 3,
  parameter logic [31:0] VPN_MASK = 32'hFFFF_FC00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mmu_mode,
  input  logic [1:0]          acc_lvl,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [RN_BITS-1:0]  reg_num,
  input  logic                ext,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_data,
  output logic [IDX_BITS-1:0] ent_idx,
  input  logic [DW-1:0]       ent_rd_tag,
  input  logic [2*DW-1:0]     ent_rd_lo,
  input  logic [TID_BITS-1:0] ent_rd_tid,
  output logic                ent_we_tag,
  output logic                ent_we_lo,
  output logic                ent_we_up,
  output logic [DW-1:0]       ent_wdata,
  output logic [TID_BITS-1:0] ent_wtid,
  output logic                srch_req,
  output logic [DW-1:0]       srch_vpn,
  input  logic                srch_hit,
  input  logic [IDX_BITS-1:0] srch_idx,
  output logic [TID_BITS-1:0] pid_o,
  output logic [DW-1:0]       zone_o
);
  localparam logic [RN_BITS-1:0] RN_LO  = RN_BITS'(0);
  localparam logic [RN_BITS-1:0] RN_HI  = RN_BITS'(1);
  localparam logic [RN_BITS-1:0] RN_PID = RN_BITS'(2);
  localparam logic [RN_BITS-1:0] RN_ZPR = RN_BITS'(3);
  localparam logic [RN_BITS-1:0] RN_IDX = RN_BITS'(4);
  localparam logic [RN_BITS-1:0] RN_SX  = RN_BITS'(5);
  localparam int MSB = DW - 1;

  logic [DW-1:0] idx_q, pid_q, zpr_q;

  logic mmu_on, go, rd_priv, wr_priv;
  assign mmu_on  = (mmu_mode >= 2'd2) && (acc_lvl != 2'd0);
  assign go      = mmu_on && (!ext || reg_num == RN_LO);
  assign rd_priv = acc_lvl[0];
  assign wr_priv = acc_lvl[1];

  logic wr_go, pid_wr, zpr_wr, idx_wr, tid_load;
  assign wr_go    = wr_en && go;
  assign pid_wr   = wr_go && reg_num == RN_PID && wr_priv;
  assign zpr_wr   = wr_go && reg_num == RN_ZPR && wr_priv;
  assign idx_wr   = wr_go && reg_num == RN_IDX;
  assign tid_load = rd_en && go && reg_num == RN_HI && rd_priv;

  assign ent_we_tag = wr_go && reg_num == RN_HI;
  assign ent_we_lo  = wr_go && reg_num == RN_LO && !ext;
  assign ent_we_up  = wr_go && reg_num == RN_LO && ext;
  assign ent_wdata  = wdata;
  assign ent_wtid   = pid_q[TID_BITS-1:0];
  assign srch_req   = wr_go && reg_num == RN_SX && wr_priv;
  assign srch_vpn   = wdata & VPN_MASK;

  assign ent_idx = idx_q[IDX_BITS-1:0];
  assign pid_o   = pid_q[TID_BITS-1:0];
  assign zone_o  = zpr_q;

  always_comb begin
    rd_data = '0;
    if (go) begin
      case (reg_num)
        RN_LO:   if (rd_priv) rd_data = ext ? ent_rd_lo[2*DW-1:DW] : ent_rd_lo[DW-1:0];
        RN_HI:   if (rd_priv) rd_data = ent_rd_tag;
        RN_PID:  if (rd_priv) rd_data = pid_q;
        RN_ZPR:  if (rd_priv) rd_data = zpr_q;
        RN_IDX:  rd_data = idx_q;
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      pid_q <= '0;
      zpr_q <= '0;
    end else begin
      if (idx_wr)
        idx_q <= {idx_q[MSB], wdata[MSB-1:0]};
      else if (srch_req)
        idx_q <= srch_hit ? DW'(srch_idx) : (idx_q | (DW'(1) << MSB));
      if (pid_wr)
        pid_q <= wdata;
      else if (tid_load)
        pid_q <= DW'(ent_rd_tid);
      if (zpr_wr)
        zpr_q <= wdata;
    end
  end
endmodule

// File: rtl/tlb_reg_ctrl_chk.sv
module tlb_reg_ctrl_chk #(
  parameter int DW       = 32,
  parameter int IDX_BITS = 8,
  parameter int TID_BITS = 8,
  parameter int RN_BITS  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mmu_mode,
  input logic [1:0]          acc_lvl,
  input logic                rd_en,
  input logic                wr_en,
  input logic [RN_BITS-1:0]  reg_num,
  input logic                ext,
  input logic [DW-1:0]       wdata,
  input logic [DW-1:0]       rd_data,
  input logic [IDX_BITS-1:0] ent_idx,
  input logic [TID_BITS-1:0] ent_rd_tid,
  input logic                ent_we_tag,
  input logic                ent_we_lo,
  input logic                ent_we_up,
  input logic [TID_BITS-1:0] ent_wtid,
  input logic                srch_req,
  input logic                srch_hit,
  input logic [IDX_BITS-1:0] srch_idx,
  input logic [TID_BITS-1:0] pid_o,
  input logic [DW-1:0]       zone_o
);
  logic off;
  assign off = (mmu_mode < 2'd2) || (acc_lvl == 2'd0);

  // R2
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (!ent_we_tag && !ent_we_lo && !ent_we_up && !srch_req && rd_data == '0));

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> ($stable(pid_o) && $stable(zone_o) && $stable(ent_idx)));

  // R11
  ext_only_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext && reg_num != '0) |-> (!ent_we_tag && !ent_we_lo && !srch_req && rd_data == '0));

  // R10
  search_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lvl < 2'd2) |-> !srch_req);

  // R4
  tag_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we_tag |-> (ent_wtid == pid_o));

  // R6
  idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !off && !ext && reg_num == RN_BITS'(4)) |=> (ent_idx == $past(wdata[IDX_BITS-1:0])));

  // R7
  search_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_req && srch_hit) |=> (ent_idx == $past(srch_idx)));

  // R5
  tid_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !off && !ext && acc_lvl[0] && reg_num == RN_BITS'(1))
      |=> (pid_o == $past(ent_rd_tid)));
endmodule

bind tlb_reg_ctrl tlb_reg_ctrl_chk #(
  .DW(DW), .IDX_BITS(IDX_BITS), .TID_BITS(TID_BITS), .RN_BITS(RN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mmu_mode(mmu_mode), .acc_lvl(acc_lvl),
  .rd_en(rd_en), .wr_en(wr_en), .reg_num(reg_num), .ext(ext), .wdata(wdata),
  .rd_data(rd_data), .ent_idx(ent_idx), .ent_rd_tid(ent_rd_tid),
  .ent_we_tag(ent_we_tag), .ent_we_lo(ent_we_lo), .ent_we_up(ent_we_up),
  .ent_wtid(ent_wtid), .srch_req(srch_req), .srch_hit(srch_hit),
  .srch_idx(srch_idx), .pid_o(pid_o), .zone_o(zone_o)
);

// File: tb/tlb_reg_ctrl_tb.sv
`timescale 1ns/1ps
module tlb_reg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mmu_mode = 2'd3;
  logic [1:0]  acc_lvl = 2'd3;
  logic        rd_en = 1'b0, wr_en = 1'b0, ext = 1'b0;
  logic [2:0]  reg_num = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [7:0]  ent_idx;
  logic [31:0] ent_rd_tag;
  logic [63:0] ent_rd_lo;
  logic [7:0]  ent_rd_tid;
  logic        ent_we_tag, ent_we_lo, ent_we_up;
  logic [31:0] ent_wdata;
  logic [7:0]  ent_wtid;
  logic        srch_req;
  logic [31:0] srch_vpn;
  logic        srch_hit = 1'b0;
  logic [7:0]  srch_idx = '0;
  logic [7:0]  pid_o;
  logic [31:0] zone_o;

  always #4 clk = ~clk;

  tlb_reg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mmu_mode(mmu_mode), .acc_lvl(acc_lvl),
    .rd_en(rd_en), .wr_en(wr_en), .reg_num(reg_num), .ext(ext), .wdata(wdata),
    .rd_data(rd_data), .ent_idx(ent_idx), .ent_rd_tag(ent_rd_tag),
    .ent_rd_lo(ent_rd_lo), .ent_rd_tid(ent_rd_tid), .ent_we_tag(ent_we_tag),
    .ent_we_lo(ent_we_lo), .ent_we_up(ent_we_up), .ent_wdata(ent_wdata),
    .ent_wtid(ent_wtid), .srch_req(srch_req), .srch_vpn(srch_vpn),
    .srch_hit(srch_hit), .srch_idx(srch_idx), .pid_o(pid_o), .zone_o(zone_o)
  );

  // entry storage model
  logic [31:0] m_tag [256];
  logic [63:0] m_lo  [256];
  logic [7:0]  m_tid [256];
  initial for (int i = 0; i < 256; i++) begin m_tag[i] = '0; m_lo[i] = '0; m_tid[i] = '0; end
  always @(posedge clk) begin
    if (ent_we_tag) begin m_tag[ent_idx] <= ent_wdata; m_tid[ent_idx] <= ent_wtid; end
    if (ent_we_lo) m_lo[ent_idx][31:0]  <= ent_wdata;
    if (ent_we_up) m_lo[ent_idx][63:32] <= ent_wdata;
  end
  assign ent_rd_tag = m_tag[ent_idx];
  assign ent_rd_lo  = m_lo[ent_idx];
  assign ent_rd_tid = m_tid[ent_idx];

  int total = 0, bad = 0;
  bit finished = 0;
  logic st_tag, st_lo, st_up, st_sreq;
  logic [31:0] st_wd, st_vpn;
  logic [7:0]  st_tid;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] n, input logic e, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_num = n; ext = e; wdata = d;
    #1;
    st_tag = ent_we_tag; st_lo = ent_we_lo; st_up = ent_we_up; st_sreq = srch_req;
    st_wd = ent_wdata; st_vpn = srch_vpn; st_tid = ent_wtid;
    @(negedge clk);
    wr_en = 1'b0; ext = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] n, input logic e, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_num = n; ext = e;
    #1;
    d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; ext = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [2:0]  num;
    logic        ex;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  // wr=1: d is written; wr=0: d is the expected read value
  localparam vec_t VEC [0:15] = '{
    '{1'b1, 3'd4, 1'b0, 32'h8000_0005, 4'd6},
    '{1'b0, 3'd4, 1'b0, 32'h0000_0005, 4'd6},   // R6 bit 31 not writable
    '{1'b1, 3'd3, 1'b0, 32'h1234_5678, 4'd13},
    '{1'b0, 3'd3, 1'b0, 32'h1234_5678, 4'd13},  // R13 next-cycle read
    '{1'b1, 3'd2, 1'b0, 32'h0000_00A7, 4'd13},
    '{1'b0, 3'd2, 1'b0, 32'h0000_00A7, 4'd13},
    '{1'b1, 3'd1, 1'b0, 32'hDEAD_0010, 4'd4},
    '{1'b1, 3'd0, 1'b0, 32'h1111_2222, 4'd4},
    '{1'b1, 3'd0, 1'b1, 32'h3333_4444, 4'd4},
    '{1'b0, 3'd0, 1'b0, 32'h1111_2222, 4'd3},   // R3 lower half
    '{1'b0, 3'd0, 1'b1, 32'h3333_4444, 4'd3},   // R3 upper half
    '{1'b0, 3'd1, 1'b0, 32'hDEAD_0010, 4'd3},
    '{1'b0, 3'd5, 1'b0, 32'h0000_0000, 4'd8},   // R8
    '{1'b0, 3'd6, 1'b0, 32'h0000_0000, 4'd12},  // R12
    '{1'b0, 3'd2, 1'b1, 32'h0000_0000, 4'd11},  // R11
    '{1'b0, 3'd2, 1'b0, 32'h0000_00A7, 4'd5}    // R5: tag read copied TID A7 back
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd(3'd4, 1'b0, r); chk("R1 idx", r, 32'h0);
    do_rd(3'd2, 1'b0, r); chk("R1 pid", r, 32'h0);
    do_rd(3'd3, 1'b0, r); chk("R1 zone", r, 32'h0);

    for (int k = 0; k < 16; k++) begin
      if (VEC[k].wr) begin
        do_wr(VEC[k].num, VEC[k].ex, VEC[k].d);
      end else begin
        do_rd(VEC[k].num, VEC[k].ex, r);
        chk($sformatf("R%0d vec%0d", VEC[k].req, k), r, VEC[k].d);
      end
    end

    // R4 strobes and captured identifier
    do_wr(3'd1, 1'b0, 32'hCAFE_0400);
    chk("R4 tag strobe", {31'b0, st_tag}, 32'h1);
    chk("R4 tag tid", {24'b0, st_tid}, 32'h0000_00A7);
    chk("R4 tag data", st_wd, 32'hCAFE_0400);
    do_wr(3'd0, 1'b1, 32'h5555_0000);
    chk("R4 upper strobe", {30'b0, st_lo, st_up}, 32'h1);

    // R5 identifier copy from a different slot
    do_wr(3'd4, 1'b0, 32'h0000_0009);
    do_wr(3'd2, 1'b0, 32'h0000_003C);
    do_wr(3'd1, 1'b0, 32'h0000_0400);
    do_wr(3'd2, 1'b0, 32'h0000_0011);
    do_rd(3'd1, 1'b0, r);
    do_rd(3'd2, 1'b0, r); chk("R5 pid from tid", r, 32'h0000_003C);

    // R7 search hit, miss, sticky flag
    do_wr(3'd4, 1'b0, 32'h4000_0003);
    srch_hit = 1'b1; srch_idx = 8'h2A;
    do_wr(3'd5, 1'b0, 32'h1234_5678);
    chk("R7 search req", {31'b0, st_sreq}, 32'h1);
    chk("R7 search vpn", st_vpn, 32'h1234_5400);
    do_rd(3'd4, 1'b0, r); chk("R7 hit idx", r, 32'h0000_002A);
    do_wr(3'd4, 1'b0, 32'h0000_0007);
    srch_hit = 1'b0;
    do_wr(3'd5, 1'b0, 32'h0000_0000);
    do_rd(3'd4, 1'b0, r); chk("R7 miss flag", r, 32'h8000_0007);
    do_wr(3'd4, 1'b0, 32'h0000_0001);
    do_rd(3'd4, 1'b0, r); chk("R6 flag survives write", r, 32'h8000_0001);
    srch_hit = 1'b1; srch_idx = 8'h13;
    do_wr(3'd5, 1'b0, 32'h0000_0000);
    do_rd(3'd4, 1'b0, r); chk("R7 hit clears flag", r, 32'h0000_0013);
    srch_hit = 1'b0;

    // R10 level 1 blocks identifier, zone and search writes
    acc_lvl = 2'd1;
    do_wr(3'd2, 1'b0, 32'h0000_0055);
    do_wr(3'd3, 1'b0, 32'hFFFF_FFFF);
    do_wr(3'd5, 1'b0, 32'h0000_0000);
    chk("R10 no search at lvl1", {31'b0, st_sreq}, 32'h0);
    do_wr(3'd1, 1'b0, 32'h0000_0800);
    chk("R10 tag write at lvl1", {31'b0, st_tag}, 32'h1);
    do_rd(3'd2, 1'b0, r); chk("R10 pid kept", r, 32'h0000_003C);
    do_rd(3'd3, 1'b0, r); chk("R10 zone kept", r, 32'h1234_5678);

    // R9 level 2 masks reads except slot select
    acc_lvl = 2'd2;
    do_rd(3'd2, 1'b0, r); chk("R9 pid masked", r, 32'h0);
    do_rd(3'd1, 1'b0, r); chk("R9 tag masked", r, 32'h0);
    do_rd(3'd4, 1'b0, r); chk("R9 idx readable", r, 32'h0000_0013);
    acc_lvl = 2'd3;

    // R2 disabled port
    mmu_mode = 2'd1;
    do_rd(3'd4, 1'b0, r); chk("R2 read zero", r, 32'h0);
    do_wr(3'd4, 1'b0, 32'h0000_0077);
    do_wr(3'd1, 1'b0, 32'h0000_0C00);
    chk("R2 no tag strobe", {31'b0, st_tag}, 32'h0);
    mmu_mode = 2'd3; acc_lvl = 2'd0;
    do_rd(3'd2, 1'b0, r); chk("R2 lvl0 read zero", r, 32'h0);
    do_wr(3'd2, 1'b0, 32'h0000_0099);
    acc_lvl = 2'd3;
    do_rd(3'd4, 1'b0, r); chk("R2 idx kept", r, 32'h0000_0013);
    do_rd(3'd2, 1'b0, r); chk("R2 pid kept", r, 32'h0000_003C);

    // R11 extended access off register 0
    do_wr(3'd1, 1'b1, 32'h0000_1000);
    chk("R11 no ext tag write", {31'b0, st_tag}, 32'h0);
    do_wr(3'd2, 1'b1, 32'h0000_0066);
    do_rd(3'd2, 1'b0, r); chk("R11 pid kept", r, 32'h0000_003C);

    // R12 unused numbers
    do_wr(3'd7, 1'b0, 32'hFFFF_FFFF);
    chk("R12 no strobe", {28'b0, st_tag, st_lo, st_up, st_sreq}, 32'h0);
    do_wr(3'd6, 1'b0, 32'hFFFF_FFFF);
    do_rd(3'd3, 1'b0, r); chk("R12 zone kept", r, 32'h1234_5678);
    do_rd(3'd4, 1'b0, r); chk("R12 idx kept", r, 32'h0000_0013);
    do_rd(3'd7, 1'b0, r); chk("R12 read zero", r, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule